// File: doc/BRIEF.md
# SONET STS-1 Receive Framer with Section Parity Monitor

This block sits just after clock and data recovery on a 51 Mbit/s SONET/SDH (STS-1) receive path. It accepts one byte per valid strobe and hunts for the two framing bytes that open every frame. It then confirms the alignment against later frames and tracks it. It removes the frame-synchronous scrambling from every byte except the first three of row 0. It checks the section bit interleaved parity byte against parity computed over the previous frame as received, still scrambled.

Downstream logic gets each descrambled byte together with its row and column, a start-of-frame marker and an in-frame flag. The in-frame flag going low is the loss-of-frame alarm. A host watches link quality through a saturating parity-error counter. It reads this counter through a holding register, which a snapshot strobe loads.

Top module: `sonet_rx_framer`

## Requirements
- R1: While not aligned, the byte 0xF6 followed by 0x28 on consecutive valid bytes sets alignment. That 0x28 byte is taken as row 0, column 1. Row and column then advance by one per valid byte over 9 rows of 90 columns.
- R2: `in_frame` rises at the second consecutive correct framing pattern at the expected place (row 0, columns 0 and 1). The search hit counts as the first. A wrong pattern there before `in_frame` is set drops alignment and restarts the search.
- R3: Once `in_frame` is high, 4 consecutive wrong framing patterns clear `in_frame` and restart the search. Fewer than 4 wrong patterns followed by a correct one leave `in_frame` high.
- R4: Each output byte carries its row (0..8) and column (0..89). `out_sof` is high only with the row 0, column 0 byte. Both are zero while not aligned. The outputs appear one cycle after the input byte.
- R5: Bytes at row 0, columns 0..2 and all bytes received while not aligned pass unchanged. Every other byte is XORed with the 1+x^6+x^7 sequence, MSB first. The sequence restarts from all ones at row 0, column 3, so the first key byte is 0xFE.
- R6: The parity byte is the descrambled byte at row 1, column 0. It is compared with the even parity (XOR) of all 810 scrambled bytes of the previous frame, and the number of differing bits is added to the error counter. No check is made unless the whole previous frame was received while aligned.
- R7: The error counter saturates at 2^ERRW-1.
- R8: A `snap` pulse copies the error counter into `err_hold`. At the same time the counter restarts, holding only the increment of that cycle.
- R9: While `in_valid` is low, no framing, position, scrambler or parity state advances, and `out_valid` and `out_sof` are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Received byte, scrambled |
| snap | input | 1 | Host snapshot strobe for the error counter |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Descrambled byte |
| out_row | output | 4 | Row of the output byte |
| out_col | output | 7 | Column of the output byte |
| out_sof | output | 1 | Marks the first byte of a frame |
| in_frame | output | 1 | Frame alignment confirmed; low means loss of frame |
| err_hold | output | ERRW | Error count latched at the last snapshot |

## Verification
The bound checker checks the following on every cycle:
- the output strobe follows the input strobe by one cycle;
- start-of-frame only ever marks row 0, column 0;
- positions stay inside the frame;
- the counter never falls except at a snapshot;
- the held value equals the counter value from before the snapshot.

The other behaviours are shown by the bench scenarios, checked against its reference model:
- the confirmation and loss thresholds for framing;
- the exact descrambled values;
- parity error counts from chosen bit masks, including saturation;
- the first unchecked frame after acquisition;
- idle gaps holding a framing byte.

// File: rtl/sonet_rx_framer.sv
module sonet_rx_framer #(
  parameter int ROWS    = 9,
  parameter int COLS    = 90,
  parameter int ERRW    = 16,
  parameter int GOOD_N  = 2,
  parameter int BAD_N   = 4,
  parameter int OH_COLS = 3,
  parameter logic [7:0] SYNC1 = 8'hF6,
  parameter logic [7:0] SYNC2 = 8'h28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  input  logic            snap,
  output logic            out_valid,
  output logic [7:0]      out_byte,
  output logic [$clog2(ROWS)-1:0] out_row,
  output logic [$clog2(COLS)-1:0] out_col,
  output logic            out_sof,
  output logic            in_frame,
  output logic [ERRW-1:0] err_hold
);
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);
  localparam int CNTW = $clog2(GOOD_N + BAD_N + 1);

  logic            aligned;
  logic [RW-1:0]   row_q;
  logic [CW-1:0]   col_q;
  logic [7:0]      last_byte;
  logic [CNTW-1:0] good_q, bad_q;
  logic [6:0]      lfsr_q, lfsr_nx;
  logic [7:0]      ks;
  logic [7:0]      acc_q, bip_prev;
  logic            acc_full, bip_ok;
  logic [ERRW-1:0] err_cnt;
  logic [3:0]      inc;
  logic [ERRW:0]   sum;

  wire at_sof  = row_q == '0 && col_q == '0;
  wire at_chk  = row_q == '0 && col_q == CW'(1);
  wire at_seed = row_q == '0 && col_q == CW'(OH_COLS);
  wire at_b1   = row_q == RW'(1) && col_q == '0;
  wire at_eof  = row_q == RW'(ROWS-1) && col_q == CW'(COLS-1);
  wire pat_ok  = last_byte == SYNC1 && in_byte == SYNC2;
  wire scr_on  = aligned && !(row_q == '0 && col_q < CW'(OH_COLS));
  wire [7:0] clear_byte = in_byte ^ (scr_on ? ks : 8'h00);

  always_comb begin
    logic [6:0] st;
    st = at_seed ? 7'h7F : lfsr_q;
    for (int i = 7; i >= 0; i--) begin
      ks[i] = st[6];
      st = {st[5:0], st[6] ^ st[5]};
    end
    lfsr_nx = st;
  end

  assign inc = (in_valid && aligned && at_b1 && bip_ok) ? 4'($countones(clear_byte ^ bip_prev)) : 4'd0;
  assign sum = {1'b0, err_cnt} + (ERRW+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned <= 1'b0; in_frame <= 1'b0;
      row_q <= '0; col_q <= '0; last_byte <= '0;
      good_q <= '0; bad_q <= '0; lfsr_q <= '1;
      acc_q <= '0; bip_prev <= '0; acc_full <= 1'b0; bip_ok <= 1'b0;
      err_cnt <= '0; err_hold <= '0;
      out_valid <= 1'b0; out_byte <= '0; out_row <= '0; out_col <= '0; out_sof <= 1'b0;
    end else begin
      if (snap) begin
        err_hold <= err_cnt;
        err_cnt  <= ERRW'(inc);
      end else begin
        err_cnt <= sum[ERRW] ? '1 : sum[ERRW-1:0];
      end
      out_valid <= in_valid;
      if (!in_valid) out_sof <= 1'b0;
      if (in_valid) begin
        last_byte <= in_byte;
        out_byte  <= clear_byte;
        out_row   <= aligned ? row_q : '0;
        out_col   <= aligned ? col_q : '0;
        out_sof   <= aligned && at_sof;
        if (!aligned) begin
          if (pat_ok) begin
            aligned <= 1'b1;
            row_q <= '0; col_q <= CW'(2);
            good_q <= CNTW'(1); bad_q <= '0;
            acc_q <= '0; acc_full <= 1'b0; bip_ok <= 1'b0;
          end
        end else begin
          if (col_q == CW'(COLS-1)) begin
            col_q <= '0;
            row_q <= (row_q == RW'(ROWS-1)) ? '0 : row_q + 1'b1;
          end else begin
            col_q <= col_q + 1'b1;
          end
          lfsr_q <= lfsr_nx;
          if (at_sof) begin
            acc_q <= in_byte; acc_full <= 1'b1;
          end else begin
            acc_q <= acc_q ^ in_byte;
          end
          if (at_eof) begin
            bip_prev <= acc_q ^ in_byte; bip_ok <= acc_full;
          end
          if (at_chk) begin
            if (pat_ok) begin
              bad_q <= '0;
              if (good_q < CNTW'(GOOD_N)) good_q <= good_q + 1'b1;
              if (good_q >= CNTW'(GOOD_N-1)) in_frame <= 1'b1;
            end else begin
              good_q <= '0;
              if (!in_frame) begin
                aligned <= 1'b0;
              end else if (bad_q == CNTW'(BAD_N-1)) begin
                in_frame <= 1'b0; aligned <= 1'b0; bad_q <= '0;
              end else begin
                bad_q <= bad_q + 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

module sonet_rx_framer_chk #(
  parameter int ROWS = 9,
  parameter int COLS = 90,
  parameter int ERRW = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    snap,
  input logic                    out_valid,
  input logic                    out_sof,
  input logic [$clog2(ROWS)-1:0] out_row,
  input logic [$clog2(COLS)-1:0] out_col,
  input logic                    in_frame,
  input logic [ERRW-1:0]         err_cnt,
  input logic [ERRW-1:0]         err_hold
);
  // R9
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_sof));
  // R4
  sof_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_row == '0 && out_col == '0));
  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(out_row) < ROWS && int'(out_col) < COLS));
  // R2
  lock_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(in_valid));
  // R3
  loss_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> $past(in_valid));
  // R7
  no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> err_cnt >= $past(err_cnt));
  // R8
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> err_hold == $past(err_cnt));
endmodule

bind sonet_rx_framer sonet_rx_framer_chk #(.ROWS(ROWS), .COLS(COLS), .ERRW(ERRW)) u_chk (.*);

// File: tb/sonet_rx_framer_bench.sv
module sonet_rx_framer_bench;
  localparam int EW = 6;
  localparam int NB = 810;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic snap = 1'b0;
  logic out_valid, out_sof, in_frame;
  logic [7:0] out_byte;
  logic [3:0] out_row;
  logic [6:0] out_col;
  logic [EW-1:0] err_hold;

  always #10 clk = ~clk;

  sonet_rx_framer #(.ERRW(EW)) u_sonet_rx_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .snap(snap),
    .out_valid(out_valid), .out_byte(out_byte), .out_row(out_row), .out_col(out_col),
    .out_sof(out_sof), .in_frame(in_frame), .err_hold(err_hold));

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // keystream table, bit-serial generator from all ones
  logic [7:0] key [0:NB-4];
  initial begin
    int r;
    r = 127;
    for (int k = 0; k < NB-3; k++) begin
      int v;
      v = 0;
      for (int b = 0; b < 8; b++) begin
        int o;
        o = (r >> 6) & 1;
        v = (v << 1) | o;
        r = ((r << 1) | (((r >> 6) ^ (r >> 5)) & 1)) & 127;
      end
      key[k] = 8'(v);
    end
  end

  // reference model
  int m_al, m_if, m_pos, m_prev, m_good, m_bad, m_acc, m_bipp, m_full, m_bok, m_cnt, m_hold;
  int e_valid, e_byte, e_row, e_col, e_sof;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_al = 0; m_if = 0; m_pos = 0; m_prev = 0; m_good = 0; m_bad = 0;
      m_acc = 0; m_bipp = 0; m_full = 0; m_bok = 0; m_cnt = 0; m_hold = 0;
      e_valid = 0; e_byte = 0; e_row = 0; e_col = 0; e_sof = 0;
    end else begin
      int add, p, k, b;
      add = 0;
      e_valid = in_valid;
      if (!in_valid) e_sof = 0;
      else begin
        b = in_byte;
        p = m_al ? m_pos : -1;
        k = (p >= 3) ? key[p-3] : 0;
        e_byte = b ^ k;
        e_row = m_al ? p / 90 : 0;
        e_col = m_al ? p % 90 : 0;
        e_sof = (p == 0);
        if (p == 90 && m_bok) add = $countones(8'(b ^ k ^ m_bipp));
        if (!m_al) begin
          if (m_prev == 8'hF6 && b == 8'h28) begin
            m_al = 1; m_pos = 2; m_good = 1; m_bad = 0; m_acc = 0; m_full = 0; m_bok = 0;
          end
        end else begin
          if (p == 0) begin m_acc = b; m_full = 1; end else m_acc = m_acc ^ b;
          if (p == NB-1) begin m_bipp = m_acc; m_bok = m_full; end
          m_pos = (p + 1) % NB;
          if (p == 1) begin
            if (m_prev == 8'hF6 && b == 8'h28) begin
              m_bad = 0; m_good++;
              if (m_good >= 2) m_if = 1;
            end else begin
              m_good = 0;
              if (!m_if) m_al = 0;
              else begin
                m_bad++;
                if (m_bad == 4) begin m_if = 0; m_al = 0; m_bad = 0; end
              end
            end
          end
        end
        m_prev = b;
      end
      if (snap) begin m_hold = m_cnt; m_cnt = add; end
      else m_cnt = (m_cnt + add > 63) ? 63 : m_cnt + add;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == e_valid[0], "R9 out_valid", out_valid, e_valid);
      chk(in_frame == m_if[0], "R2/R3 in_frame", in_frame, m_if);
      chk(err_hold == EW'(m_hold), "R8 err_hold", err_hold, m_hold);
      if (e_valid != 0) begin
        chk(out_byte == 8'(e_byte), "R5 out_byte", out_byte, e_byte);
        chk(out_row == 4'(e_row) && out_col == 7'(e_col), "R4 position", out_row*100+out_col, e_row*100+e_col);
        chk(out_sof == e_sof[0], "R4 out_sof", out_sof, e_sof);
      end
    end
  end

  int gapc = 0;
  int fnum = 0;
  logic [7:0] prev_bip = 8'h00;

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    gapc++;
    if (gapc % 13 == 0) begin
      @(negedge clk);
      in_valid = 1'b0; in_byte = 8'hF6;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_byte = 8'h28;
    end
  endtask

  task automatic send_frame(input bit a1_good, input logic [7:0] mask);
    logic [7:0] fr [0:NB-1];
    logic [7:0] acc, sc;
    for (int i = 0; i < NB; i++) fr[i] = 8'(i*53 + fnum*17 + 9);
    fr[0] = a1_good ? 8'hF6 : 8'hF7;
    fr[1] = 8'h28;
    fr[2] = 8'h01;
    fr[90] = prev_bip ^ mask;
    acc = 8'h00;
    for (int i = 0; i < NB; i++) begin
      sc = (i >= 3) ? fr[i] ^ key[i-3] : fr[i];
      acc = acc ^ sc;
      put(sc);
    end
    prev_bip = acc;
    fnum++;
  endtask

  task automatic do_snap();
    @(negedge clk);
    in_valid = 1'b0; snap = 1'b1;
    @(negedge clk);
    snap = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_sof == 1'b0, "R9 reset strobes", out_valid, 0);
    chk(in_frame == 1'b0 && err_hold == '0, "R2 reset state", in_frame, 0);
    chk(out_row == '0 && out_col == '0, "R4 reset position", out_row*100+out_col, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 50; i++) put(8'((i*29 + 5) & 8'h7F));
    send_frame(1'b1, 8'h00);
    chk(in_frame == 1'b0, "R2 not yet in frame after search hit", in_frame, 0);
    send_frame(1'b1, 8'hFF);
    chk(in_frame == 1'b1, "R2 in frame after second pattern", in_frame, 1);
    do_snap();
    chk(err_hold == 0, "R6 first frame after lock unchecked", err_hold, 0);
    send_frame(1'b1, 8'h00);
    send_frame(1'b1, 8'h00);
    send_frame(1'b1, 8'h05);
    do_snap();
    chk(err_hold == 2, "R6 two parity bits wrong", err_hold, 2);
    send_frame(1'b1, 8'h91);
    do_snap();
    chk(err_hold == 3, "R6 three parity bits wrong", err_hold, 3);
    send_frame(1'b1, 8'h00);
    do_snap();
    chk(err_hold == 0, "R8 counter restarted by snapshot", err_hold, 0);
    for (int f = 0; f < 9; f++) send_frame(1'b1, 8'hFF);
    do_snap();
    chk(err_hold == 63, "R7 counter saturates", err_hold, 63);
    for (int f = 0; f < 3; f++) send_frame(1'b0, 8'h00);
    chk(in_frame == 1'b1, "R3 three bad patterns keep frame", in_frame, 1);
    send_frame(1'b1, 8'h00);
    chk(in_frame == 1'b1, "R3 good pattern after three bad", in_frame, 1);
    for (int f = 0; f < 4; f++) send_frame(1'b0, 8'h00);
    chk(in_frame == 1'b0, "R3 four bad patterns lose frame", in_frame, 0);
    for (int f = 0; f < 4; f++) send_frame(1'b1, 8'h00);
    chk(in_frame == 1'b1, "R1 alignment found again", in_frame, 1);
    idle(4);
    chk(out_valid == 1'b0, "R9 idle gives no output", out_valid, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule